// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single output line. Bytes go into a small first-in first-out buffer. A shift stage then sends each byte as one start bit (low), eight data bits with the least significant bit first, and one stop bit (high). The line rests high between frames. A bit lasts sixteen cycles of an oversampling enable.

The oversampling enable comes from one of two sources. The first is an internal divider of the system clock. The second is an external clock at sixteen times the bit rate, which is resynchronised and edge-detected. When the internal source is chosen, the block drives the sixteen-times clock out on a clock pin and raises its output enable.

A transmit-enable input controls the shift stage only. Dropping it abandons the current frame and puts the line at mark at once. The buffer and the flags are not touched. A separate flush input empties the buffer, which clears out stale data after an aborted transfer. A transmit-end flag tells the host that the buffer is empty and that the last stop bit has fully left the line.

Top module: `utx_fifo_tx`

## Requirements
- R1: After reset, `txd` is 1, `fifo_empty` is 1, `fifo_full` is 0, `ovf` is 0 and `tx_end` is 1.
- R2: Each frame is a low start bit, then eight data bits starting from bit 0, then a high stop bit. `txd` is 1 whenever no frame is being sent.
- R3: Every bit of a frame lasts exactly 16 oversampling ticks. While `tx_en` stays high, `txd` changes only in the cycle after a tick.
- R4: With `clk_sel` = 0, a tick occurs once every `baud_div` system clocks, and values 0 and 1 behave as 1. With `clk_sel` = 1, a tick occurs once per rising edge of `ext_clk16`, detected after a two-flop synchroniser.
- R5: With `clk_sel` = 0, `sck_oe` is 1 and `sck_out` is a square wave with one period per tick. It is high for the first `baud_div`/2 cycles of each period. With `clk_sel` = 1, `sck_oe` and `sck_out` are both 0.
- R6: While `tx_en` is 0, `txd` is 1. It goes to 1 in the same cycle that `tx_en` falls, even in the middle of a frame, and the partial frame is abandoned.
- R7: While `tx_en` is 0, nothing is removed from the buffer. `fifo_empty`, `fifo_full`, `ovf` and `tx_end` keep their values unless a write or a flush changes them.
- R8: A high `fifo_rst` in a cycle empties the buffer and clears `ovf` at the next edge. A write in the same cycle is dropped.
- R9: `tx_end` goes to 1 at the end of a stop bit when the buffer is empty. It goes to 0 when a write is accepted while `tx_en` is 1, and when a frame is loaded for sending.
- R10: The buffer holds 16 bytes. `fifo_full` is 1 when it holds 16. A write while full is dropped, and `ovf` is then set and stays set until a flush or reset.
- R11: Writes accepted while `tx_en` is 0 are kept and do not clear `tx_end`. After `tx_en` rises, they are sent in write order, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable for the shift stage |
| clk_sel | input | 1 | 0 = internal divider, 1 = external 16x clock |
| baud_div | input | 16 | Internal divider ratio in system clocks per tick |
| ext_clk16 | input | 1 | External 16x serial clock |
| fifo_rst | input | 1 | Flush the transmit buffer and clear overflow |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Buffer holds 16 bytes |
| fifo_empty | output | 1 | Buffer holds no bytes |
| ovf | output | 1 | Sticky flag: a write was dropped while full |
| tx_end | output | 1 | Buffer empty and last stop bit finished |
| txd | output | 1 | Serial data line |
| sck_out | output | 1 | 16x clock driven out when internal source is used |
| sck_oe | output | 1 | Output enable for the clock pin |

## Verification
The hardest state to reach from the ports is an abort in the middle of a frame. The line must be at mark, the buffer must still hold its unsent bytes, and the flags must be frozen at their values from mid-transfer. The bench reaches it in three steps. It queues three bytes with the frame monitor switched off. It lets the first frame run about a third of the way through. It then drops `tx_en` between clock edges and probes `txd` before the next edge. After that it checks that the buffer is still not empty and that the flags are unchanged. It then flushes, and it checks that a fresh byte is sent cleanly once transmission is enabled again.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int OVERSAMPLE = 16;
    localparam int FRAME_BITS = 10;
    localparam int PH_W       = $clog2(OVERSAMPLE);
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_e;

    typedef struct packed {
        logic [FRAME_BITS-1:0] bits;
        logic [IDX_W-1:0]      idx;
        logic [PH_W-1:0]       phase;
    } shift_ctx_t;

    function automatic logic [FRAME_BITS-1:0] pack_frame(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

endpackage

// File: rtl/utx_tick_gen.sv
module utx_tick_gen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_clk,
    output logic             tick,
    output logic             sck_out,
    output logic             sck_oe
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;
    logic             wrap;
    logic [SH_W-1:0]  sync_q;
    logic             ext_rise;

    assign last = (div <= DIV_W'(1)) ? '0 : div - DIV_W'(1);
    assign wrap = (cnt >= last);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= wrap ? '0 : cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SH_W-2:0], ext_clk};
    end

    assign ext_rise = sync_q[SH_W-2] & ~sync_q[SH_W-1];

    assign tick    = ext_sel ? ext_rise : wrap;
    assign sck_oe  = ~ext_sel;
    assign sck_out = ~ext_sel & (cnt < (div >> 1));

endmodule

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          empty,
    output logic          ovf,
    output logic          accepted
);

    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wptr, rptr;
    logic          do_pop;

    assign empty    = (wptr == rptr);
    assign full     = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
    assign accepted = push & ~full & ~flush;
    assign do_pop   = pop & ~empty & ~flush;
    assign dout     = mem[rptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (accepted) mem[wptr[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (accepted) wptr <= wptr + 1'b1;
            if (do_pop)   rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)               ovf <= 1'b0;
        else if (push && full)          ovf <= 1'b1;
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       tick,
    input  logic       src_empty,
    input  logic [7:0] src_data,
    output logic       pop,
    output logic       frame_done,
    output logic       txd
);

    sh_state_e  state;
    shift_ctx_t ctx;
    logic       bit_end, last_bit;

    assign bit_end    = (ctx.phase == PH_W'(OVERSAMPLE - 1));
    assign last_bit   = bit_end && (ctx.idx == IDX_W'(FRAME_BITS - 1));
    assign frame_done = tick && tx_en && (state == SH_BUSY) && last_bit;
    assign pop        = tick && tx_en && !src_empty &&
                        ((state == SH_IDLE) || last_bit);
    assign txd        = (tx_en && state == SH_BUSY) ? ctx.bits[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            state <= SH_IDLE;
            ctx   <= '{bits: '1, idx: '0, phase: '0};
        end else if (tick) begin
            if (pop) begin
                state <= SH_BUSY;
                ctx   <= '{bits: pack_frame(src_data), idx: '0, phase: '0};
            end else if (state == SH_BUSY) begin
                if (last_bit) begin
                    state <= SH_IDLE;
                    ctx   <= '{bits: '1, idx: '0, phase: '0};
                end else begin
                    ctx.phase <= ctx.phase + 1'b1;
                    if (bit_end) begin
                        ctx.bits <= {1'b1, ctx.bits[FRAME_BITS-1:1]};
                        ctx.idx  <= ctx.idx + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/utx_fifo_tx.sv
module utx_fifo_tx
    import utx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             clk_sel,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             ext_clk16,
    input  logic             fifo_rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    output logic             fifo_full,
    output logic             fifo_empty,
    output logic             ovf,
    output logic             tx_end,
    output logic             txd,
    output logic             sck_out,
    output logic             sck_oe
);

    logic       tick;
    logic       pop, frame_done, wr_ok;
    logic [7:0] head;

    utx_tick_gen #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_tick (
        .clk(clk), .rst(rst), .ext_sel(clk_sel), .div(baud_div),
        .ext_clk(ext_clk16), .tick(tick), .sck_out(sck_out), .sck_oe(sck_oe)
    );

    utx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst(rst), .flush(fifo_rst), .push(wr_valid),
        .din(wr_data), .pop(pop), .dout(head), .full(fifo_full),
        .empty(fifo_empty), .ovf(ovf), .accepted(wr_ok)
    );

    utx_shifter u_shift (
        .clk(clk), .rst(rst), .tx_en(tx_en), .tick(tick),
        .src_empty(fifo_empty), .src_data(head), .pop(pop),
        .frame_done(frame_done), .txd(txd)
    );

    always_ff @(posedge clk) begin
        if (rst)                              tx_end <= 1'b1;
        else if ((wr_ok && tx_en) || pop)     tx_end <= 1'b0;
        else if (frame_done && fifo_empty)    tx_end <= 1'b1;
    end

endmodule

// File: rtl/utx_fifo_tx_chk.sv
module utx_fifo_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic fifo_rst,
    input logic wr_valid,
    input logic fifo_full,
    input logic fifo_empty,
    input logic ovf,
    input logic tx_end,
    input logic txd,
    input logic tick
);

    // R10
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && wr_valid && !fifo_rst) |=> ovf);

    // R7
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !wr_valid && !fifo_rst) |=> ($stable(fifo_empty) && $stable(tx_end)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |=> (fifo_empty && !ovf));

    // R3
    txd_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_en && $past(tx_en) && !$stable(txd)) |-> $past(tick));

    // R9
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && tx_en && !fifo_full && !fifo_rst) |=> !tx_end);

    // R10
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

endmodule

bind utx_fifo_tx utx_fifo_tx_chk u_chk (
    .clk(clk), .rst(rst), .tx_en(tx_en), .fifo_rst(fifo_rst),
    .wr_valid(wr_valid), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .ovf(ovf), .tx_end(tx_end), .txd(txd), .tick(tick)
);

// File: tb/utx_fifo_tx_tb.sv
module utx_fifo_tx_tb;

    logic        clk = 1'b0;
    logic        rst, tx_en, clk_sel, ext_clk16, fifo_rst, wr_valid;
    logic [15:0] baud_div;
    logic [7:0]  wr_data;
    logic        fifo_full, fifo_empty, ovf, tx_end, txd, sck_out, sck_oe;

    always #2 clk = ~clk;

    utx_fifo_tx u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .clk_sel(clk_sel),
        .baud_div(baud_div), .ext_clk16(ext_clk16), .fifo_rst(fifo_rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .ovf(ovf), .tx_end(tx_end), .txd(txd),
        .sck_out(sck_out), .sck_oe(sck_oe)
    );

    int tests = 0;
    int fails = 0;
    bit ext_run = 1'b0;
    bit mon_on  = 1'b0;
    int bit_clks = 32;
    int sent_n = 0;
    int got_n  = 0;
    logic [7:0] exp_q [$];

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // external 16x clock: period 4 system clocks
    always #8 ext_clk16 = ext_run ? ~ext_clk16 : 1'b0;

    // driver
    task automatic put(input logic [7:0] b, input bit expect_sent);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_sent) begin
            exp_q.push_back(b);
            sent_n++;
        end
    endtask

    // monitor / scoreboard
    initial begin
        logic prev;
        logic [7:0] b;
        logic s_ok, p_ok;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_on && prev === 1'b1 && txd === 1'b0) begin
                repeat (bit_clks / 2) @(negedge clk);
                s_ok = (txd == 1'b0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bit_clks) @(negedge clk);
                    b[i] = txd;
                end
                repeat (bit_clks) @(negedge clk);
                p_ok = (txd == 1'b1);
                if (exp_q.size() == 0) begin
                    chk("R2 unexpected frame", 32'(b), 32'hfff);
                end else begin
                    chk("R2 frame data LSB first", 32'(b), 32'(exp_q.pop_front()));
                    chk("R3 start low / stop high at bit centres", {30'd0, s_ok, p_ok}, 3);
                end
                got_n++;
                prev = 1'b1;
            end else begin
                prev = txd;
            end
        end
    end

    task automatic drain();
        wait (got_n == sent_n);
        repeat (bit_clks) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int rises;
        logic last_sck;
        rst = 1'b1; tx_en = 1'b0; clk_sel = 1'b0; baud_div = 16'd2;
        fifo_rst = 1'b0; wr_valid = 1'b0; wr_data = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 fifo_empty", fifo_empty, 1);
        chk("R1 fifo_full", fifo_full, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 tx_end", tx_end, 1);

        // internal clock, back-to-back bytes
        mon_on = 1'b1; tx_en = 1'b1; bit_clks = 32;
        put(8'hA5, 1'b1);
        chk("R9 tx_end cleared by write", tx_end, 0);
        put(8'h3C, 1'b1);
        put(8'h01, 1'b1);
        put(8'hFF, 1'b1);
        drain();
        chk("R9 tx_end after last stop bit", tx_end, 1);
        chk("R2 fifo drained", fifo_empty, 1);

        // clock pin, internal source
        baud_div = 16'd4;
        @(negedge clk);
        chk("R5 sck_oe internal", sck_oe, 1);
        rises = 0; last_sck = sck_out;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sck_out && !last_sck) rises++;
            last_sck = sck_out;
        end
        chk("R5 sck_out periods in 64 clocks", rises, 16);
        // R4 internal divider 4 -> 64-clock bits
        bit_clks = 64;
        put(8'h69, 1'b1);
        drain();

        // external clock source
        clk_sel = 1'b1; ext_run = 1'b1; bit_clks = 64;
        repeat (4) @(negedge clk);
        chk("R5 sck_oe external", sck_oe, 0);
        chk("R5 sck_out external", sck_out, 0);
        put(8'h5A, 1'b1);
        put(8'h80, 1'b1);
        drain();
        chk("R4 tx_end after external frames", tx_end, 1);
        clk_sel = 1'b0; ext_run = 1'b0; baud_div = 16'd2; bit_clks = 32;

        // fill while disabled, overflow
        tx_en = 1'b0;
        for (int i = 0; i < 17; i++) put(8'(8'h10 + i), (i < 16));
        chk("R10 fifo_full", fifo_full, 1);
        chk("R10 ovf set", ovf, 1);
        chk("R11 tx_end kept while disabled", tx_end, 1);
        chk("R11 line idle while disabled", txd, 1);
        tx_en = 1'b1;
        drain();
        chk("R10 ovf sticky", ovf, 1);
        chk("R11 all queued bytes sent", fifo_empty, 1);

        // abort in mid-frame
        mon_on = 1'b0;
        put(8'hC3, 1'b0);
        put(8'h96, 1'b0);
        put(8'h0F, 1'b0);
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        #1;
        chk("R6 mark right after disable", txd, 1);
        chk("R7 fifo keeps bytes", fifo_empty, 0);
        chk("R7 tx_end unchanged", tx_end, 0);
        chk("R7 ovf unchanged", ovf, 1);
        repeat (200) @(negedge clk);
        chk("R6 mark held", txd, 1);
        chk("R7 fifo still holds", fifo_empty, 0);
        fifo_rst = 1'b1;
        @(negedge clk);
        fifo_rst = 1'b0;
        chk("R8 flush empties", fifo_empty, 1);
        chk("R8 flush clears ovf", ovf, 0);
        mon_on = 1'b1;
        tx_en = 1'b1;
        put(8'h42, 1'b1);
        drain();
        chk("R9 tx_end after restart", tx_end, 1);
        chk("R2 no stray frames", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule